// File: doc/BRIEF.md
# Pulse Accumulator with Status Flags

This block counts external events into a 16-bit accumulator. A single input pin is synchronised to the system clock and then used in one of two ways. In event mode, every active edge on the pin adds one to the count. In gated mode, the pin acts as a gate, and the count advances on each tick from an external prescaler while the gate is at its active level. One control bit selects the active edge, and that same bit sets the gate polarity.

Two sticky status flags record activity. The wrap flag is raised when the count rolls over from its largest value to zero. The pin flag is raised on each counted edge in event mode, and on the closing (trailing) edge of the gate in gated mode. Each flag has its own interrupt enable, and the enabled flags are ORed into one request line. Software clears a flag by writing a one to it. When the fast-clear option is on, any read or write of either counter byte clears both flags at once.

Software reaches the block through a small synchronous register bus with four byte-wide registers. Reads are combinational.

Top module: `pacc_top`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is low. Register addresses are: 0 = control, 1 = flags, 2 = count high byte, 3 = count low byte. In the flags register, bits 7..2 always read 0.
- R2: Event mode is control bit1 = 0. In this mode, each active edge on `pin_in` adds one to the count, and edges of the opposite direction are not counted. Control bit2 selects the active edge: 0 = rising, 1 = falling. The count changes on the third rising clock edge after the pin changes (two synchroniser stages, then the counter).
- R3: When the count steps from 0xFFFF, it becomes 0x0000 and the wrap flag (flags bit1) is set.
- R4: In event mode, each active edge sets the pin flag (flags bit0).
- R5: Gated mode is control bit1 = 1. In this mode, the count advances by one on each cycle where `tick_in` is high and the synchronised pin is at its gate level. The gate level is high when bit2 = 0 and low when bit2 = 1. Ticks outside the gate are not counted.
- R6: In gated mode, the pin flag is set on the trailing edge of the gate and not on its leading edge.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. Writes to bits 7..2 have no effect.
- R8: When fast-clear (control bit5) is 1, a read or write of either count byte clears both flags. When bit5 is 0, such accesses leave the flags alone.
- R9: `irq` = (wrap flag AND control bit3) OR (pin flag AND control bit4).
- R10: If a flag is set by hardware in the same cycle that software clears it, the flag ends up set.
- R11: While the enable bit (control bit0) is 0, the count does not advance and no flag is set.
- R12: The count high and low bytes can be written and read back on their own. A bus write to the count takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when not selected |
| pin_in | input | 1 | Asynchronous event / gate input |
| tick_in | input | 1 | Prescaler tick for gated mode |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to create is the clash between a hardware flag set and a software clear in the same cycle. The flag set lands three clock edges after the pin moves, so the bench drives the pin, counts two falling edges, and then issues the clear write so that both meet at the same rising edge. The wrap is reached by first loading 0xFFFF over the bus. After that, random event pulses, count writes and flag clears are mixed in, and each result is compared with a model kept inside the bench.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int FLAG_N  = 2;
    localparam int SYNC_N  = 2;
    localparam int CTRL_W  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNTH  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNTL  = 2'd3;

    localparam int F_PIN  = 0;
    localparam int F_WRAP = 1;

    typedef enum logic [0:0] {
        M_EVENT = 1'b0,
        M_GATED = 1'b1
    } mode_e;

    typedef struct packed {
        logic  fast_clr;
        logic  pin_ie;
        logic  wrap_ie;
        logic  edge_fall;
        mode_e mode;
        logic  en;
    } ctrl_t;

    typedef struct packed {
        logic wrap;
        logic pin;
    } flags_t;

    function automatic logic irq_of(flags_t f, ctrl_t c);
        return (f.wrap & c.wrap_ie) | (f.pin & c.pin_ie);
    endfunction

    function automatic logic is_cnt_addr(logic [ADDR_W-1:0] a);
        return (a == A_CNTH) || (a == A_CNTL);
    endfunction
endpackage

// File: rtl/pacc_event_logic.sv
module pacc_event_logic
    import pacc_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_in,
    input  logic  tick_in,
    input  ctrl_t ctrl,
    output logic  inc,
    output logic  set_pin
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              lvl, rise, fall, act_edge, trail_edge, gate_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                if (i == 0) sh_q[i] <= pin_in;
                else        sh_q[i] <= sh_q[i-1];
            end
            prev_q <= sh_q[STAGES-1];
        end
    end

    always_comb begin
        lvl        = sh_q[STAGES-1];
        rise       = lvl & ~prev_q;
        fall       = ~lvl & prev_q;
        act_edge   = ctrl.edge_fall ? fall : rise;
        trail_edge = ctrl.edge_fall ? rise : fall;
        gate_on    = lvl ^ ctrl.edge_fall;
        if (ctrl.mode == M_EVENT) begin
            inc     = ctrl.en & act_edge;
            set_pin = ctrl.en & act_edge;
        end else begin
            inc     = ctrl.en & tick_in & gate_on;
            set_pin = ctrl.en & trail_edge;
        end
    end

    // R6: in gated mode a leading edge alone never raises the flag request
    a_r6_no_lead_flag: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == M_GATED && (ctrl.edge_fall ? fall : rise)) |-> !set_pin);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter
    import pacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);
    logic wr_any;

    assign wr_any = wr_hi | wr_lo;
    assign wrap   = inc & ~wr_any & (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_any) begin
            if (wr_hi) cnt[CNT_W-1:BYTE_W] <= wdata;
            if (wr_lo) cnt[BYTE_W-1:0]     <= wdata;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_any && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr_any) |=> $stable(cnt));
    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (cnt[BYTE_W-1:0] == $past(wdata)));
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags
    import pacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] set_v,
    input  logic              wr_flags,
    input  logic [FLAG_N-1:0] wbits,
    input  logic              fast_hit,
    output logic [FLAG_N-1:0] flag_q
);
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        logic clr;
        assign clr = fast_hit | (wr_flags & wbits[i]);

        always_ff @(posedge clk) begin
            if (rst)           flag_q[i] <= 1'b0;
            else if (set_v[i]) flag_q[i] <= 1'b1;
            else if (clr)      flag_q[i] <= 1'b0;
        end

        a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> flag_q[i]);
        a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
            (wr_flags && !wbits[i] && !fast_hit && flag_q[i]) |=> flag_q[i]);
        a_r8_fast_wipes: assert property (@(posedge clk) disable iff (rst)
            (fast_hit && !set_v[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              pin_in,
    input  logic              tick_in,
    output logic              irq
);
    ctrl_t             ctrl_q;
    flags_t            flags;
    logic [FLAG_N-1:0] flag_vec, set_vec;
    logic [CNT_W-1:0]  cnt;
    logic              inc, set_pin, wrap;
    logic              wr_ctrl, wr_flags, wr_hi, wr_lo, fast_hit;

    assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == A_CTRL);
    assign wr_flags = bus_sel & bus_wr & (bus_addr == A_FLAGS);
    assign wr_hi    = bus_sel & bus_wr & (bus_addr == A_CNTH);
    assign wr_lo    = bus_sel & bus_wr & (bus_addr == A_CNTL);
    assign fast_hit = bus_sel & ctrl_q.fast_clr & is_cnt_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    pacc_event_logic #(.STAGES(SYNC_N)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .tick_in (tick_in),
        .ctrl    (ctrl_q),
        .inc     (inc),
        .set_pin (set_pin)
    );

    pacc_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc),
        .wr_hi (wr_hi),
        .wr_lo (wr_lo),
        .wdata (bus_wdata),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[F_PIN]  = set_pin;
        set_vec[F_WRAP] = wrap;
    end

    pacc_flags u_flg (
        .clk      (clk),
        .rst      (rst),
        .set_v    (set_vec),
        .wr_flags (wr_flags),
        .wbits    (bus_wdata[FLAG_N-1:0]),
        .fast_hit (fast_hit),
        .flag_q   (flag_vec)
    );

    assign flags = flags_t'(flag_vec);
    assign irq   = irq_of(flags, ctrl_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
                A_FLAGS: bus_rdata = {{(BYTE_W-FLAG_N){1'b0}}, flag_vec};
                A_CNTH:  bus_rdata = cnt[CNT_W-1:BYTE_W];
                default: bus_rdata = cnt[BYTE_W-1:0];
            endcase
        end
    end

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.wrap_ie && !ctrl_q.pin_ie) |-> !irq);
    a_r1_flags_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == A_FLAGS) |-> (bus_rdata[BYTE_W-1:FLAG_N] == '0));
    a_r11_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !wr_hi && !wr_lo) |=> $stable(cnt));
endmodule

// File: tb/tb_pacc_top.sv
`timescale 1ns/1ps
module tb_pacc_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pin_in = 1'b0, tick_in = 1'b0;
    logic       irq;

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [15:0] e_cnt = 16'd0;
    logic        e_wrap = 1'b0, e_pin = 1'b0;

    pacc_top dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    function automatic logic [16:0] step(logic [15:0] c);
        return {1'b0, c} + 17'd1;
    endfunction

    task automatic model_event();
        logic [16:0] n;
        n = step(e_cnt);
        e_cnt = n[15:0];
        if (n[16]) e_wrap = 1;
        e_pin = 1;
    endtask

    task automatic set_pin(logic v, int hold);
        @(negedge clk);
        pin_in = v;
        repeat (hold) @(negedge clk);
    endtask

    task automatic check_state(string req);
        logic [7:0] h, l, f;
        rd(2'd2, h); rd(2'd3, l); rd(2'd1, f);
        check(req, {h, l}, e_cnt);
        check(req, {8'd0, f}, {14'd0, e_wrap, e_pin});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 reset reg", {8'd0, d}, 16'd0);
        end
        check("R1 irq reset", {15'd0, irq}, 16'd0);

        // R11: disabled, edges ignored
        set_pin(1, 4); set_pin(0, 4);
        check_state("R11 disabled");

        // R2/R4 event rising
        wr(2'd0, 8'h01);
        set_pin(1, 4);
        model_event();
        check_state("R2 R4 rising edge counted");
        set_pin(0, 4);
        check_state("R2 falling not counted");

        // R7 write 0 keeps, write 1 clears, upper bits
        wr(2'd1, 8'hFC);
        check_state("R7 zero write keeps");
        wr(2'd1, 8'h01); e_pin = 0;
        check_state("R7 one write clears");

        // R12 count bytes, R3 wrap
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); e_cnt = 16'hFFFF;
        check_state("R12 count write");
        set_pin(1, 4); model_event(); set_pin(0, 4);
        check_state("R3 wrap");

        // R9 irq masking
        check("R9 irq masked", {15'd0, irq}, 16'd0);
        wr(2'd0, 8'h09);
        @(negedge clk); check("R9 wrap irq", {15'd0, irq}, 16'd1);
        wr(2'd1, 8'h02); e_wrap = 0;
        @(negedge clk); check("R9 pin flag unenabled", {15'd0, irq}, 16'd0);
        wr(2'd0, 8'h11);
        @(negedge clk); check("R9 pin irq", {15'd0, irq}, 16'd1);

        // R8 fast clear off: count access keeps flags
        rd(2'd3, d);
        check_state("R8 no fast clear");
        wr(2'd0, 8'h21);
        rd(2'd2, d); e_pin = 0; e_wrap = 0;
        check_state("R8 fast clear on read");
        set_pin(1, 4); model_event(); set_pin(0, 4);
        wr(2'd3, 8'h40); e_cnt[7:0] = 8'h40; e_pin = 0;
        check_state("R8 fast clear on write");
        wr(2'd0, 8'h01);

        // R10 collision: flag set and clear in same cycle
        wr(2'd1, 8'h03); e_pin = 0; e_wrap = 0;
        @(negedge clk); pin_in = 1;
        @(negedge clk); @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h01;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        model_event();
        check_state("R10 set wins");
        set_pin(0, 4);

        // R2 falling edge config
        wr(2'd0, 8'h00); set_pin(1, 4);
        wr(2'd0, 8'h05);
        set_pin(0, 4); model_event();
        check_state("R2 falling edge counted");
        set_pin(1, 4);
        check_state("R2 rising ignored when falling selected");

        // R5/R6 gated, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            wr(2'd0, 8'h00); set_pin(pol[0], 4);
            wr(2'd1, 8'h03); e_pin = 0; e_wrap = 0;
            wr(2'd0, {5'd0, pol[0], 2'b11});
            repeat (20) begin
                @(negedge clk); tick_in = 1'($urandom);
            end
            @(negedge clk); tick_in = 0;
            check_state("R5 ticks outside gate ignored");
            set_pin(~pol[0], 4);
            check_state("R6 leading edge no flag");
            for (int k = 0; k < 30; k++) begin
                @(negedge clk); tick_in = 1'($urandom);
                if (tick_in) begin
                    logic [16:0] n;
                    n = step(e_cnt); e_cnt = n[15:0];
                    if (n[16]) e_wrap = 1;
                end
            end
            @(negedge clk); tick_in = 0;
            check_state("R5 gated ticks counted");
            set_pin(pol[0], 4); e_pin = 1;
            check_state("R6 trailing edge flag");
        end

        // Random event-mode mix
        wr(2'd0, 8'h00); set_pin(0, 4); wr(2'd0, 8'h01);
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 4)
                0, 1: begin
                    set_pin(1, 3 + $urandom % 4); model_event();
                    set_pin(0, 3 + $urandom % 4);
                end
                2: begin
                    d = 8'($urandom);
                    if ($urandom % 2) begin wr(2'd2, d); e_cnt[15:8] = d; end
                    else begin wr(2'd3, d); e_cnt[7:0] = d; end
                end
                default: begin
                    d = 8'($urandom);
                    wr(2'd1, d);
                    if (d[0]) e_pin = 0;
                    if (d[1]) e_wrap = 0;
                end
            endcase
            check_state("R2 R3 R4 R7 R12 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule